// File: doc/BRIEF.md
# Serial Audio Frame Receiver (TDM / I2S)

This block recovers parallel audio samples from a three-wire serial link made of a bit clock, a frame sync and a data line. It never drives a clock. The bit clock always comes from outside: either the companion transmitter's clock path or the pin. The three pins are brought into the system clock domain and sampled on each rising bit-clock edge. The bits of every slot in a frame are then packed into one right-aligned word. Each word leaves the block as a one-cycle pulse that carries the index of the slot it came from.

The format comes from a 32-bit configuration word whose packing matches the transmitter's. The receiver drops the transmitter-only fields: the sync pulse width and the follower/leader selector. A flush request clears a half-built word and unlocks the frame tracker. Software issues it between transfers, so that each transfer starts from the same clean state and the channels keep their slot positions.

Top module: `rxa_serial_rx`

## Requirements
- R1: After reset, `smp_valid_o` and `sync_err_o` are 0. The receiver is unlocked and emits no sample until it detects a frame sync edge.
- R2: In TDM mode, cfg bits [17:14] give the slot count per frame, and the value 0 means 16 slots. The slot counter restarts at 0 at a frame sync edge, and each sample carries its slot index on `smp_slot_o`.
- R3: In TDM mode, cfg bit 13 sets the slot width: 1 gives 16 bits, 0 gives 32 bits. Exactly one sample is emitted at the last bit of every slot.
- R4: cfg bits [12:8] give the number of sample bits B, and the value 0, or any value above the slot width, means the full slot. If cfg bit 7 is 0, the sample is the first B bits of the slot. If cfg bit 7 is 1, it is the last B bits of the slot. The sample is output right-aligned and zero-extended, so B = 24 with 32-bit slots returns 24 bits.
- R5: When cfg bit 6 is 1, the bit sampled with the sync edge ends the previous frame, and frame bit 0 follows one bit clock later. When cfg bit 6 is 0, the bit sampled with the sync edge is frame bit 0.
- R6: cfg bit 31 selects the mode. When it is 1 (TDM), a rising sync edge starts a frame. When it is 0 (I2S), a falling sync edge starts a frame of two 32-bit slots, and bits [17:13] are ignored.
- R7: cfg bit 30 and bits [25:18] have no effect on the received samples.
- R8: If a sync edge arrives while the tracker is locked but not at a frame boundary, the frame restarts at slot 0. `sync_err_o` is then set and stays set until reset.
- R9: A `flush_i` pulse takes effect at the next rising bit-clock edge. It discards any partial word, drops the bit sampled at that edge and unlocks the tracker, so no sample is emitted until the next sync edge. It does not change `sync_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 32 | Packed format word, held stable while receiving |
| flush_i | input | 1 | Request to discard partial data and unlock |
| bclk_i | input | 1 | Serial bit clock (external) |
| fsync_i | input | 1 | Frame sync / left-right clock |
| sdata_i | input | 1 | Serial data line |
| smp_valid_o | output | 1 | One-cycle pulse for each completed slot |
| smp_data_o | output | 32 | Right-aligned sample |
| smp_slot_o | output | 4 | Slot index of the sample |
| sync_err_o | output | 1 | Sticky frame-sync mismatch flag |

## Verification
Two states are hard to reach from the ports. One is a flush that lands mid-frame while a partial word sits in the shifter. The other is a sync edge that comes early relative to the programmed frame length. To reach the first, the bench stops the bit clock part-way through a slot, pulses the flush, and then resumes the same frame with no sync. No sample may come out until the next frame's sync. To reach the second, the bench cuts a frame short in mid-slot and starts the next frame at once. It then checks that slot numbering restarts at 0 and that the error flag stays set across later clean frames until reset.

// File: rtl/rxa_pkg.sv
// Package: shared constants, format record and configuration decode for the
// serial audio receiver. Assumes the packed word layout shared with the
// transmitter; the receiver reads only the fields that shape reception.
package rxa_pkg;

    localparam int MAX_SLOT_BITS = 32;
    localparam int MAX_SLOTS     = 16;
    localparam int BIT_IW        = $clog2(MAX_SLOT_BITS);
    localparam int SLOT_IW       = $clog2(MAX_SLOTS);
    localparam int BPS_W         = BIT_IW + 1;
    localparam int CFG_W         = 32;

    localparam int CFG_MODE_BIT  = 31;
    localparam int CFG_SLOTS_LSB = 14;
    localparam int CFG_HALF_BIT  = 13;
    localparam int CFG_BPS_LSB   = 8;
    localparam int CFG_LSBJ_BIT  = 7;
    localparam int CFG_LATE_BIT  = 6;

    typedef struct packed {
        logic               tdm;
        logic [SLOT_IW-1:0] slots_m1;
        logic [BIT_IW-1:0]  width_m1;
        logic [BPS_W-1:0]   bps;
        logic               lsb_first;
        logic               late_start;
    } rx_fmt_t;

    // Turn the packed word into the effective reception format.
    function automatic rx_fmt_t decode_fmt(input logic [CFG_W-1:0] c);
        rx_fmt_t           f;
        logic [BPS_W-1:0]  wlen;
        logic [BIT_IW-1:0] bf;
        f.tdm = c[CFG_MODE_BIT];
        if (f.tdm) begin
            f.slots_m1 = c[CFG_SLOTS_LSB +: SLOT_IW] - SLOT_IW'(1);
            f.width_m1 = c[CFG_HALF_BIT] ? BIT_IW'(15) : BIT_IW'(MAX_SLOT_BITS - 1);
        end else begin
            f.slots_m1 = SLOT_IW'(1);
            f.width_m1 = BIT_IW'(MAX_SLOT_BITS - 1);
        end
        wlen = {1'b0, f.width_m1} + BPS_W'(1);
        bf   = c[CFG_BPS_LSB +: BIT_IW];
        f.bps = ((bf == '0) || ({1'b0, bf} > wlen)) ? wlen : {1'b0, bf};
        f.lsb_first  = c[CFG_LSBJ_BIT];
        f.late_start = c[CFG_LATE_BIT];
        return f;
    endfunction

endpackage

// File: rtl/rxa_pin_sync.sv
// Module: rxa_pin_sync
// Brings bit clock, frame sync and data into the system clock domain and
// flags each rising bit-clock edge. Assumes each bit-clock phase lasts at
// least two system clocks; the three pins share one pipeline so that the
// sync and data bits stay aligned with the detected edge.
module rxa_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    input  logic sdata_i,
    output logic bit_evt_o,
    output logic fs_o,
    output logic sd_o
);
    localparam int LANES = 3;

    logic [LANES-1:0] pipe_q [STAGES];
    logic             bclk_d_q;

    // Shift the pin levels through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            pipe_q[0] <= {bclk_i, fsync_i, sdata_i};
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            bclk_d_q <= pipe_q[STAGES-1][2];
        end
    end

    assign bit_evt_o = pipe_q[STAGES-1][2] & ~bclk_d_q;
    assign fs_o      = pipe_q[STAGES-1][1];
    assign sd_o      = pipe_q[STAGES-1][0];
endmodule

// File: rtl/rxa_frame_track.sv
// Module: rxa_frame_track
// Locates each received bit inside the frame (slot, bit) from sync edges.
// Locks at the first sync edge, checks later edges against the frame
// length, resyncs on mismatch and raises a sticky error. A flush request
// is held until the next bit event, where it unlocks and marks a drop.
// Assumes the format is stable whenever the tracker is locked.
module rxa_frame_track
    import rxa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tdm_i,
    input  logic               late_i,
    input  logic [SLOT_IW-1:0] slots_m1_i,
    input  logic [BIT_IW-1:0]  width_m1_i,
    input  logic               bit_evt_i,
    input  logic               fs_i,
    input  logic               flush_i,
    output logic               use_o,
    output logic               drop_o,
    output logic [SLOT_IW-1:0] slot_o,
    output logic [BIT_IW-1:0]  bit_o,
    output logic               err_o
);
    logic               locked_q, fs_prev_q, pend_q, err_q;
    logic [SLOT_IW-1:0] slot_q, nslot;
    logic [BIT_IW-1:0]  bit_q, nbit;
    logic               sync_edge, at_last, at_first, mism, lock_d;

    // Decode this bit's position and the next expected position.
    always_comb begin
        sync_edge = tdm_i ? (fs_i & ~fs_prev_q) : (~fs_i & fs_prev_q);
        at_last   = (slot_q == slots_m1_i) && (bit_q == width_m1_i);
        at_first  = (slot_q == '0) && (bit_q == '0);
        use_o  = 1'b0;
        drop_o = 1'b0;
        mism   = 1'b0;
        slot_o = slot_q;
        bit_o  = bit_q;
        lock_d = locked_q;
        nslot  = slot_q;
        nbit   = bit_q;
        if (bit_evt_i) begin
            if (pend_q) begin
                drop_o = 1'b1;
                lock_d = 1'b0;
                nslot  = '0;
                nbit   = '0;
            end else if (sync_edge) begin
                lock_d = 1'b1;
                if (late_i) begin
                    mism  = locked_q & ~at_last;
                    use_o = locked_q & at_last;
                    nslot = '0;
                    nbit  = '0;
                end else begin
                    mism   = locked_q & ~at_first;
                    use_o  = 1'b1;
                    slot_o = '0;
                    bit_o  = '0;
                    nslot  = '0;
                    nbit   = BIT_IW'(1);
                end
            end else if (locked_q) begin
                use_o = 1'b1;
                if (bit_q == width_m1_i) begin
                    nbit  = '0;
                    nslot = (slot_q == slots_m1_i) ? '0 : slot_q + SLOT_IW'(1);
                end else begin
                    nbit  = bit_q + BIT_IW'(1);
                end
            end
        end
    end

    // Update position, lock, pending flush and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q  <= 1'b0;
            fs_prev_q <= 1'b0;
            pend_q    <= 1'b0;
            err_q     <= 1'b0;
            slot_q    <= '0;
            bit_q     <= '0;
        end else begin
            locked_q <= lock_d;
            slot_q   <= nslot;
            bit_q    <= nbit;
            pend_q   <= flush_i | (pend_q & ~bit_evt_i);
            err_q    <= err_q | mism;
            if (bit_evt_i) fs_prev_q <= fs_i;
        end
    end

    assign err_o = err_q;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q) else $error("sync error flag dropped");

    assert_flush_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_evt_i && pend_q) |=> !locked_q) else $error("flush did not unlock");

    assert_pos_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |-> (bit_q <= width_m1_i) && (slot_q <= slots_m1_i))
        else $error("frame position out of range");
endmodule

// File: rtl/rxa_word_asm.sv
// Module: rxa_word_asm
// Shifts in the bits that fall inside the sample window of each slot and
// emits the right-aligned word on the slot's last bit. The window is the
// first or the last B bits of the slot, chosen by justification. Assumes
// the position inputs come from the frame tracker for the same bit event.
module rxa_word_asm
    import rxa_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lsb_first_i,
    input  logic [BPS_W-1:0]         bps_i,
    input  logic [BIT_IW-1:0]        width_m1_i,
    input  logic                     use_i,
    input  logic                     drop_i,
    input  logic [SLOT_IW-1:0]       slot_i,
    input  logic [BIT_IW-1:0]        bit_i,
    input  logic                     sd_i,
    output logic                     valid_o,
    output logic [MAX_SLOT_BITS-1:0] data_o,
    output logic [SLOT_IW-1:0]       slot_o
);
    localparam int DW = MAX_SLOT_BITS;

    logic [DW-1:0]      sh_q, base, nsh, data_q;
    logic [SLOT_IW-1:0] slot_q;
    logic               valid_q, in_win;
    logic [BPS_W-1:0]   wlen, win_lo, win_hi, bx;

    // Work out whether this bit belongs to the sample and the new shift value.
    always_comb begin
        wlen   = {1'b0, width_m1_i} + BPS_W'(1);
        win_lo = lsb_first_i ? (wlen - bps_i) : '0;
        win_hi = lsb_first_i ? wlen : bps_i;
        bx     = {1'b0, bit_i};
        in_win = (bx >= win_lo) && (bx < win_hi);
        base   = (bit_i == '0) ? '0 : sh_q;
        nsh    = in_win ? {base[DW-2:0], sd_i} : base;
    end

    // Accumulate bits and publish the word at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            data_q  <= '0;
            slot_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (drop_i) begin
                sh_q <= '0;
            end else if (use_i) begin
                if (bit_i == width_m1_i) begin
                    data_q  <= nsh;
                    slot_q  <= slot_i;
                    valid_q <= 1'b1;
                    sh_q    <= '0;
                end else begin
                    sh_q <= nsh;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign slot_o  = slot_q;

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q) else $error("back-to-back sample pulses");

    assert_right_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((data_q >> bps_i) == '0)) else $error("bits above sample width");
endmodule

// File: rtl/rxa_serial_rx.sv
// Module: rxa_serial_rx (top)
// Serial audio receiver: synchronizes the pins, tracks frame position and
// assembles per-slot samples tagged with their slot index. Always slaved to
// the external bit clock. Assumes cfg_i changes only while idle or in reset.
module rxa_serial_rx
    import rxa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CFG_W-1:0]         cfg_i,
    input  logic                     flush_i,
    input  logic                     bclk_i,
    input  logic                     fsync_i,
    input  logic                     sdata_i,
    output logic                     smp_valid_o,
    output logic [MAX_SLOT_BITS-1:0] smp_data_o,
    output logic [SLOT_IW-1:0]       smp_slot_o,
    output logic                     sync_err_o
);
    rx_fmt_t            fmt;
    logic               bit_evt, fs_bit, sd_bit, use_bit, drop_bit;
    logic [SLOT_IW-1:0] cur_slot;
    logic [BIT_IW-1:0]  cur_bit;
    logic               unused_cfg;

    assign fmt = decode_fmt(cfg_i);
    // Transmitter-only fields: leader/follower select and sync pulse width.
    assign unused_cfg = ^{cfg_i[30], cfg_i[25:18], cfg_i[5:0], cfg_i[29:26]};

    rxa_pin_sync #(.STAGES(SYNC_STAGES)) pins_i (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
        .sdata_i(sdata_i), .bit_evt_o(bit_evt), .fs_o(fs_bit), .sd_o(sd_bit)
    );

    rxa_frame_track track_i (
        .clk(clk), .rst_n(rst_n), .tdm_i(fmt.tdm), .late_i(fmt.late_start),
        .slots_m1_i(fmt.slots_m1), .width_m1_i(fmt.width_m1),
        .bit_evt_i(bit_evt), .fs_i(fs_bit), .flush_i(flush_i),
        .use_o(use_bit), .drop_o(drop_bit), .slot_o(cur_slot), .bit_o(cur_bit),
        .err_o(sync_err_o)
    );

    rxa_word_asm asm_i (
        .clk(clk), .rst_n(rst_n), .lsb_first_i(fmt.lsb_first), .bps_i(fmt.bps),
        .width_m1_i(fmt.width_m1), .use_i(use_bit), .drop_i(drop_bit),
        .slot_i(cur_slot), .bit_i(cur_bit), .sd_i(sd_bit),
        .valid_o(smp_valid_o), .data_o(smp_data_o), .slot_o(smp_slot_o)
    );

    assert_slot_tag_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (smp_slot_o <= fmt.slots_m1)) else $error("slot tag out of range");
endmodule

// File: tb/rxa_serial_rx_tb_top.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
module rxa_serial_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg = '0;
    logic        flush = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic [3:0]  smp_slot;
    logic        sync_err;

    int total = 0;
    int fails = 0;

    logic [31:0] cap_data [64];
    logic [3:0]  cap_slot [64];
    int          cap_n = 0;
    logic [31:0] exp_data [64];
    logic [3:0]  exp_slot [64];
    int          exp_n = 0;

    always #2 clk = ~clk;

    rxa_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .flush_i(flush),
        .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
        .smp_valid_o(smp_valid), .smp_data_o(smp_data),
        .smp_slot_o(smp_slot), .sync_err_o(sync_err)
    );

    // Capture emitted samples away from the active edge.
    always @(negedge clk) begin
        if (rst_n && smp_valid && cap_n < 64) begin
            cap_data[cap_n] = smp_data;
            cap_slot[cap_n] = smp_slot;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_cfg(bit tdm, int slots_f, bit half, int bps,
                                           bit lsb, bit late, bit junk);
        logic [31:0] c = '0;
        c[31] = tdm; c[17:14] = 4'(slots_f); c[13] = half; c[12:8] = 5'(bps);
        c[7] = lsb; c[6] = late;
        if (junk) begin c[30] = 1'b1; c[25:18] = 8'hA7; end
        return c;
    endfunction

    function automatic logic [31:0] pat(int f, int s, int w);
        logic [31:0] v = 32'h9E3779B9 * 32'(f * 16 + s + 1);
        v = v ^ {v[15:0], v[31:16]};
        if (w == 16) v = {16'h0, v[15:0]};
        return v;
    endfunction

    function automatic logic [31:0] exp_of(logic [31:0] v, int w, int b, bit lsb);
        logic [63:0] m = (64'd1 << b) - 64'd1;
        return lsb ? (v & m[31:0]) : (v >> (w - b));
    endfunction

    function automatic bit fs_for(bit tdm, bit late, int p, int fr);
        if (tdm) return late ? (p == fr - 1) : (p == 0);
        return ((p + 32'(late)) % 64) >= 32;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; flush = 1'b0; bclk = 1'b0; fsync = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0; exp_n = 0;
    endtask

    task automatic send_bit(input bit fs, input bit sd);
        @(negedge clk);
        bclk = 1'b0; fsync = fs; sdata = sd;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_span(bit tdm, bit late, int ns, int w, int f, int plo, int phi);
        for (int p = plo; p <= phi; p++) begin
            logic [31:0] v = pat(f, p / w, w);
            send_bit(fs_for(tdm, late, p, ns * w), v[w - 1 - (p % w)]);
        end
    endtask

    task automatic send_lead(bit tdm, bit late, int fr);
        send_bit(tdm ? 1'b0 : 1'b1, 1'b0);
        send_bit(fs_for(tdm, late, fr - 1, fr), 1'b0);
    endtask

    task automatic push_exp(int f, int s, int w, int b, bit lsb);
        exp_data[exp_n] = exp_of(pat(f, s, w), w, b, lsb);
        exp_slot[exp_n] = 4'(s);
        exp_n++;
    endtask

    task automatic settle();
        @(negedge clk); bclk = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic compare(input string req);
        chk(cap_n == exp_n, req, "sample count", 64'(cap_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_data[i] == exp_data[i], req, $sformatf("data[%0d]", i),
                64'(cap_data[i]), 64'(exp_data[i]));
            chk(cap_slot[i] == exp_slot[i], req, $sformatf("slot[%0d]", i),
                64'(cap_slot[i]), 64'(exp_slot[i]));
        end
    endtask

    task automatic run_stream(string req, bit tdm, bit late, int ns, int w, int b,
                              bit lsb, int nf, int base);
        int fr = ns * w;
        send_lead(tdm, late, fr);
        for (int f = 0; f < nf; f++) begin
            send_span(tdm, late, ns, w, base + f, 0, fr - 1);
            for (int s = 0; s < ns; s++) push_exp(base + f, s, w, b, lsb);
        end
        send_span(tdm, late, ns, w, base + nf, 0, 4);
        settle();
        compare(req);
        chk(sync_err == 1'b0, "R8", "no false sync error", 64'(sync_err), 64'd0);
    endtask

    // R1: reset values; no output without a sync edge.
    task automatic t_reset();
        cfg = mk_cfg(1, 4, 1, 0, 0, 0, 0);
        do_reset();
        chk(smp_valid == 1'b0, "R1", "valid after reset", 64'(smp_valid), 64'd0);
        chk(sync_err == 1'b0, "R1", "error after reset", 64'(sync_err), 64'd0);
        for (int i = 0; i < 40; i++) send_bit(1'b0, i[0]);
        settle();
        chk(cap_n == 0, "R1", "samples before sync", 64'(cap_n), 64'd0);
    endtask

    // R2 R4 R5: 8 x 32-bit TDM, 24 MSB bits, late start.
    task automatic t_tdm32();
        cfg = mk_cfg(1, 8, 0, 24, 0, 1, 0);
        do_reset();
        run_stream("R2 R4 R5", 1, 1, 8, 32, 24, 0, 2, 1);
    endtask

    // R2 R3 R5: slot field 0 = 16 slots, 16-bit slots, same-bit start.
    task automatic t_tdm16();
        cfg = mk_cfg(1, 0, 1, 0, 0, 0, 0);
        do_reset();
        run_stream("R2 R3 R5", 1, 0, 16, 16, 16, 0, 2, 3);
    endtask

    // R4: LSB justification, last 20 bits of 32-bit slots.
    task automatic t_lsb();
        cfg = mk_cfg(1, 4, 0, 20, 1, 1, 0);
        do_reset();
        run_stream("R4", 1, 1, 4, 32, 20, 1, 2, 6);
    endtask

    // R6 R7: I2S with junk slot/width and transmitter-only fields.
    task automatic t_i2s();
        cfg = mk_cfg(0, 6, 1, 24, 0, 1, 1);
        do_reset();
        run_stream("R6 R7", 0, 1, 2, 32, 24, 0, 3, 9);
        cfg = mk_cfg(0, 3, 0, 16, 0, 0, 0);
        do_reset();
        run_stream("R6 R5", 0, 0, 2, 32, 16, 0, 2, 14);
    endtask

    // R7: ignored fields set in TDM 16-bit mode, 12 MSB bits.
    task automatic t_junk();
        cfg = mk_cfg(1, 8, 1, 12, 0, 0, 1);
        do_reset();
        run_stream("R7", 1, 0, 8, 16, 12, 0, 2, 17);
    endtask

    // R8: early sync mid-slot forces resync and a sticky error.
    task automatic t_resync();
        cfg = mk_cfg(1, 4, 1, 0, 0, 0, 0);
        do_reset();
        send_lead(1, 0, 64);
        send_span(1, 0, 4, 16, 20, 0, 63);
        for (int s = 0; s < 4; s++) push_exp(20, s, 16, 16, 0);
        send_span(1, 0, 4, 16, 21, 0, 39);
        for (int s = 0; s < 2; s++) push_exp(21, s, 16, 16, 0);
        send_span(1, 0, 4, 16, 22, 0, 63);
        send_span(1, 0, 4, 16, 23, 0, 63);
        for (int s = 0; s < 4; s++) push_exp(22, s, 16, 16, 0);
        for (int s = 0; s < 4; s++) push_exp(23, s, 16, 16, 0);
        settle();
        chk(sync_err == 1'b1, "R8", "error after early sync", 64'(sync_err), 64'd1);
        send_span(1, 0, 4, 16, 24, 0, 63);
        send_span(1, 0, 4, 16, 25, 0, 0);
        for (int s = 0; s < 4; s++) push_exp(24, s, 16, 16, 0);
        settle();
        compare("R8");
        chk(sync_err == 1'b1, "R8", "error stays set", 64'(sync_err), 64'd1);
        do_reset();
        chk(sync_err == 1'b0, "R1", "reset clears error", 64'(sync_err), 64'd0);
    endtask

    // R9: flush with bit clock stopped mid-slot, applied when it resumes.
    task automatic t_flush();
        cfg = mk_cfg(1, 4, 0, 0, 0, 0, 0);
        do_reset();
        send_lead(1, 0, 128);
        send_span(1, 0, 4, 32, 30, 0, 127);
        for (int s = 0; s < 4; s++) push_exp(30, s, 32, 32, 0);
        send_span(1, 0, 4, 32, 31, 0, 41);
        push_exp(31, 0, 32, 32, 0);
        settle();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        repeat (10) @(negedge clk);
        send_span(1, 0, 4, 32, 31, 42, 127);
        settle();
        chk(cap_n == exp_n, "R9", "no samples after flush before sync",
            64'(cap_n), 64'(exp_n));
        send_span(1, 0, 4, 32, 32, 0, 127);
        send_span(1, 0, 4, 32, 33, 0, 0);
        for (int s = 0; s < 4; s++) push_exp(32, s, 32, 32, 0);
        settle();
        compare("R9");
        chk(sync_err == 1'b0, "R9", "flush leaves error clear", 64'(sync_err), 64'd0);
    endtask

    initial begin
        t_reset();
        t_tdm32();
        t_tdm16();
        t_lsb();
        t_i2s();
        t_junk();
        t_resync();
        t_flush();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule